// File: doc/BRIEF.md
# Linear Systolic Matrix-Vector Multiplier

This block forms the product u = A·v of a signed ROWS×COLS matrix and a COLS-element vector on a one-dimensional chain of ROWS processing elements. Processing element p owns row p and keeps its own running sum. Vector elements are never broadcast. Each one enters the first element and is handed to the next element one cycle later, so every element talks only to its neighbour. Matrix rows reach the chain through delay lines whose length grows with the row index. Because of this, element p meets a[p][j] in the same cycle as v[j], even though the host presents each whole column at once.

The host pulses `start` while the block is idle. In that same cycle it presents column 0: `vec_in` = v[0] and each matrix lane p = a[p][0]. It then presents columns 1 to COLS−1 in the following cycles. Row results come out one per cycle, each with its own valid strobe. `done` marks the final row. The whole product takes ROWS+COLS−1 clock edges.

Top module: `mvm_systolic`

## Requirements
- R1: After synchronous reset, `res_out` is all zero and `res_valid`, `done` and `busy` are all low.
- R2: Operands are two's complement signed, DW bits wide. Matrix lane p sits at `mat_in[p*DW +: DW]`. If `start` is high in an idle cycle, that edge accepts a job, and column j must be present on the inputs j cycles after the accepting cycle. Row p's result is the exact sum over j of a[p][j]·v[j], as a signed ACCW = 2·DW+ceil(log2 COLS) bit value at `res_out[p*ACCW +: ACCW]`.
- R3: Count the accepting edge as edge 0. Then `res_valid[p]` is high for exactly one cycle, directly after edge p+COLS−1. At most one valid bit is high at a time, and row p+1 follows row p in the next cycle.
- R4: `done` is high for one cycle, in the same cycle as `res_valid[ROWS-1]`, that is, directly after edge ROWS+COLS−2.
- R5: `busy` is high from the cycle after the accepting edge up to and including the cycle before `done`. It is low in the `done` cycle.
- R6: A `start` pulse while `busy` is high is ignored. The schedule and results of the running job are unchanged, and no new job begins.
- R7: A `start` in the cycle in which `done` is high is accepted, which gives back-to-back jobs with no idle cycle.
- R8: Each row's `res_out` slice holds its value in every cycle in which that row's valid bit is low.
- R9: Extreme operands (all −2^(DW−1), or mixed with 2^(DW−1)−1) produce exact results with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Job request, taken only while idle |
| mat_in | input | ROWS*DW | One matrix element per row lane, column presented unskewed |
| vec_in | input | DW | Current vector element |
| res_out | output | ROWS*ACCW | Row results, one ACCW-bit slice per row |
| res_valid | output | ROWS | One-cycle strobe per row when its result is final |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse with the last row's result |

## Verification
The hardest situations to reach are a `start` that arrives while a job is still running, and a new job that starts in the very cycle the previous one finishes. In the second case the tail of one product and the head of the next share the chain. The stimulus places stray `start` pulses in both the feeding phase and the draining phase of a job, with junk on the data pins whenever no column is due. It also chains runs so that each new `start` falls exactly on the `done` cycle. A cycle-by-cycle model in the bench predicts every valid bit, `busy`, `done` and row value for every cycle, so any disturbance of the running schedule is visible.

// File: rtl/mvm_pkg.sv
package mvm_pkg;

  typedef enum logic [1:0] {
    MVM_IDLE  = 2'd0,
    MVM_FEED  = 2'd1,
    MVM_DRAIN = 2'd2
  } mvm_state_e;

  // Width that holds a sum of `terms` signed dw x dw products without wrap.
  function automatic int mvm_acc_width(input int dw, input int terms);
    return 2 * dw + $clog2(terms);
  endfunction

endpackage

// File: rtl/mvm_ctrl.sv
module mvm_ctrl #(
  parameter int COLS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tail_fire,
  output logic col_valid,
  output logic col_first,
  output logic col_last,
  output logic busy,
  output logic done
);
  import mvm_pkg::*;

  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;
  localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

  mvm_state_e      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            accept;
  logic            feeding;

  assign accept    = start && (state_q == MVM_IDLE);
  assign feeding   = (state_q == MVM_FEED);
  assign col_valid = accept || feeding;
  assign col_first = accept;
  assign col_last  = (accept && (COLS == 1)) || (feeding && (cnt_q == LAST_COL));
  assign busy      = (state_q != MVM_IDLE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      MVM_IDLE: begin
        if (accept) begin
          cnt_d   = CW'(1);
          state_d = (COLS == 1) ? MVM_DRAIN : MVM_FEED;
        end
      end
      MVM_FEED: begin
        cnt_d = cnt_q + CW'(1);
        if (col_last) state_d = MVM_DRAIN;
      end
      MVM_DRAIN: state_d = MVM_DRAIN;
      default:   state_d = MVM_IDLE;
    endcase
    // the last row finishing ends the job regardless of phase
    if (tail_fire) state_d = MVM_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= MVM_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done    <= tail_fire;
    end
  end

endmodule

// File: rtl/mvm_skew.sv
module mvm_skew #(
  parameter int DW    = 8,
  parameter int DEPTH = 1
) (
  input  logic          clk,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  // Plain shift register without reset so it can map onto shift-register LUTs.
  logic [DW-1:0] pipe [DEPTH];

  always_ff @(posedge clk) pipe[0] <= din;

  for (genvar k = 1; k < DEPTH; k++) begin : g_tap
    always_ff @(posedge clk) pipe[k] <= pipe[k-1];
  end

  assign dout = pipe[DEPTH-1];

endmodule

// File: rtl/mvm_pe.sv
module mvm_pe #(
  parameter int DW   = 8,
  parameter int ACCW = 19
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [DW-1:0]          a_in,
  input  logic [DW-1:0]          v_in,
  input  logic                   vld_in,
  input  logic                   first_in,
  input  logic                   last_in,
  output logic signed [ACCW-1:0] res,
  output logic                   res_vld
);
  logic signed [2*DW-1:0] prod;
  logic signed [ACCW-1:0] prod_x;
  logic signed [ACCW-1:0] acc_q;
  logic signed [ACCW-1:0] sum;

  assign prod   = $signed(a_in) * $signed(v_in);
  assign prod_x = ACCW'(prod);
  assign sum    = (first_in ? '0 : acc_q) + prod_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      res     <= '0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= vld_in && last_in;
      if (vld_in) acc_q <= sum;
      if (vld_in && last_in) res <= sum;
    end
  end

endmodule

// File: rtl/mvm_systolic.sv
module mvm_systolic #(
  parameter int ROWS = 4,
  parameter int COLS = 5,
  parameter int DW   = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [ROWS*DW-1:0]            mat_in,
  input  logic [DW-1:0]                 vec_in,
  output logic [ROWS*mvm_pkg::mvm_acc_width(DW, COLS)-1:0] res_out,
  output logic [ROWS-1:0]               res_valid,
  output logic                          busy,
  output logic                          done
);
  import mvm_pkg::*;

  localparam int ACCW = mvm_acc_width(DW, COLS);

  // stage p carries what PE p consumes this cycle
  logic [DW-1:0] st_v     [ROWS];
  logic          st_vld   [ROWS];
  logic          st_first [ROWS];
  logic          st_last  [ROWS];
  logic [DW-1:0] a_sk     [ROWS];
  logic          tail_fire;

  mvm_ctrl #(.COLS(COLS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .tail_fire (tail_fire),
    .col_valid (st_vld[0]),
    .col_first (st_first[0]),
    .col_last  (st_last[0]),
    .busy      (busy),
    .done      (done)
  );

  assign st_v[0]   = vec_in;
  assign tail_fire = st_vld[ROWS-1] && st_last[ROWS-1];

  for (genvar p = 0; p < ROWS; p++) begin : g_row
    if (p == 0) begin : g_head
      assign a_sk[0] = mat_in[DW-1:0];
    end else begin : g_link
      mvm_skew #(.DW(DW), .DEPTH(p)) u_skew (
        .clk  (clk),
        .din  (mat_in[p*DW +: DW]),
        .dout (a_sk[p])
      );

      always_ff @(posedge clk) st_v[p] <= st_v[p-1];

      always_ff @(posedge clk) begin
        if (rst) begin
          st_vld[p]   <= 1'b0;
          st_first[p] <= 1'b0;
          st_last[p]  <= 1'b0;
        end else begin
          st_vld[p]   <= st_vld[p-1];
          st_first[p] <= st_vld[p-1] && st_first[p-1];
          st_last[p]  <= st_vld[p-1] && st_last[p-1];
        end
      end
    end

    logic signed [ACCW-1:0] row_res;

    mvm_pe #(.DW(DW), .ACCW(ACCW)) u_pe (
      .clk      (clk),
      .rst      (rst),
      .a_in     (a_sk[p]),
      .v_in     (st_v[p]),
      .vld_in   (st_vld[p]),
      .first_in (st_first[p]),
      .last_in  (st_last[p]),
      .res      (row_res),
      .res_vld  (res_valid[p])
    );

    assign res_out[p*ACCW +: ACCW] = row_res;
  end

endmodule

// File: rtl/mvm_systolic_chk.sv
module mvm_systolic_chk #(
  parameter int ROWS = 4,
  parameter int COLS = 5,
  parameter int ACCW = 19
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic [ROWS-1:0]      res_valid,
  input logic [ROWS*ACCW-1:0] res_out
);
  int lat_q;

  always_ff @(posedge clk) begin
    if (rst)                 lat_q <= 0;
    else if (start && !busy) lat_q <= 1;
    else if (done)           lat_q <= 0;
    else if (lat_q != 0)     lat_q <= lat_q + 1;
  end

  // R3
  valid_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(res_valid));

  for (genvar k = 1; k < ROWS; k++) begin : g_order
    // R3
    valid_order_chk: assert property (@(posedge clk) disable iff (rst)
      res_valid[k-1] |=> res_valid[k]);
  end

  // R4
  done_tail_chk: assert property (@(posedge clk) disable iff (rst)
    done == res_valid[ROWS-1]);

  // R4 R6
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_q == ROWS + COLS - 1));

  // R5
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R5
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  for (genvar k = 0; k < ROWS; k++) begin : g_hold
    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !res_valid[k] |-> $stable(res_out[k*ACCW +: ACCW]));
  end

endmodule

bind mvm_systolic mvm_systolic_chk #(
  .ROWS (ROWS),
  .COLS (COLS),
  .ACCW (ACCW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .res_valid (res_valid),
  .res_out   (res_out)
);

// File: tb/test_mvm_systolic.sv
module test_mvm_systolic;
  localparam int ROWS       = 4;
  localparam int COLS       = 5;
  localparam int DW         = 8;
  localparam int ACCW       = 2 * DW + $clog2(COLS);
  localparam int CLK_PERIOD = 10;
  localparam int LAST_T     = ROWS + COLS - 2;

  logic                 clk = 1'b0;
  logic                 rst;
  logic                 start;
  logic [ROWS*DW-1:0]   mat_in;
  logic [DW-1:0]        vec_in;
  logic [ROWS*ACCW-1:0] res_out;
  logic [ROWS-1:0]      res_valid;
  logic                 busy;
  logic                 done;

  int     checks = 0;
  int     fails  = 0;
  int     A [ROWS][COLS];
  int     V [COLS];
  longint expv [ROWS];
  longint held [ROWS];

  always #(CLK_PERIOD/2) clk = ~clk;

  mvm_systolic #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) i_mvm_systolic (
    .clk(clk), .rst(rst), .start(start), .mat_in(mat_in), .vec_in(vec_in),
    .res_out(res_out), .res_valid(res_valid), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint row_out(input int p);
    logic signed [ACCW-1:0] s;
    s = res_out[p*ACCW +: ACCW];
    return longint'(s);
  endfunction

  task automatic drive_col(input int j);
    for (int p = 0; p < ROWS; p++) mat_in[p*DW +: DW] = DW'(A[p][j]);
    vec_in = DW'(V[j]);
  endtask

  task automatic drive_junk();
    for (int p = 0; p < ROWS; p++) mat_in[p*DW +: DW] = DW'($urandom);
    vec_in = DW'($urandom);
  endtask

  // one job; called at a negedge, returns at the negedge of the done cycle
  task automatic run_job(input string req, input int ghost_a, input int ghost_b);
    for (int p = 0; p < ROWS; p++) begin
      expv[p] = 0;
      for (int j = 0; j < COLS; j++) expv[p] += longint'(A[p][j]) * longint'(V[j]);
    end
    start = 1'b1;
    drive_col(0);
    for (int t = 0; t <= LAST_T; t++) begin
      @(posedge clk);
      @(negedge clk);
      for (int p = 0; p < ROWS; p++) begin
        check(res_valid[p] == (t == p + COLS - 1), "R3", $sformatf("%s valid row %0d t=%0d", req, p, t),
              longint'(res_valid[p]), longint'(t == p + COLS - 1));
        if (t == p + COLS - 1)
          check(row_out(p) == expv[p], "R2", $sformatf("%s value row %0d", req, p), row_out(p), expv[p]);
      end
      check(done == (t == LAST_T), "R4", $sformatf("%s done t=%0d", req, t),
            longint'(done), longint'(t == LAST_T));
      check(busy == (t < LAST_T), "R5", $sformatf("%s busy t=%0d", req, t),
            longint'(busy), longint'(t < LAST_T));
      start = ((t == ghost_a) || (t == ghost_b)) && (t < LAST_T);
      if (t + 1 < COLS) drive_col(t + 1);
      else drive_junk();
    end
    for (int p = 0; p < ROWS; p++) held[p] = expv[p];
  endtask

  task automatic idle_cycles(input int n);
    start = 1'b0;
    for (int k = 0; k < n; k++) begin
      drive_junk();
      @(posedge clk);
      @(negedge clk);
      check(res_valid == '0, "R8", "idle valid", longint'(res_valid), 0);
      check(!done && !busy, "R8", "idle done/busy", longint'({done, busy}), 0);
      for (int p = 0; p < ROWS; p++)
        check(row_out(p) == held[p], "R8", $sformatf("hold row %0d", p), row_out(p), held[p]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    start = 1'b0;
    mat_in = '0;
    vec_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(res_out == '0, "R1", "res_out after reset", longint'(res_out != '0), 0);
    check(res_valid == '0, "R1", "valid after reset", longint'(res_valid), 0);
    check(!done && !busy, "R1", "done/busy after reset", longint'({done, busy}), 0);

    // R2 ramp pattern
    for (int p = 0; p < ROWS; p++)
      for (int j = 0; j < COLS; j++) A[p][j] = p * COLS + j - 7;
    for (int j = 0; j < COLS; j++) V[j] = 3 - 2 * j;
    run_job("R2 ramp", -1, -1);

    // R7 back-to-back random jobs starting in the done cycle
    for (int r = 0; r < 3; r++) begin
      for (int p = 0; p < ROWS; p++)
        for (int j = 0; j < COLS; j++) A[p][j] = int'($signed(DW'($urandom)));
      for (int j = 0; j < COLS; j++) V[j] = int'($signed(DW'($urandom)));
      run_job("R7 back-to-back", -1, -1);
    end
    idle_cycles(3);

    // R9 extremes, all most-negative
    for (int p = 0; p < ROWS; p++)
      for (int j = 0; j < COLS; j++) A[p][j] = -(1 << (DW - 1));
    for (int j = 0; j < COLS; j++) V[j] = -(1 << (DW - 1));
    run_job("R9 neg*neg", -1, -1);
    idle_cycles(2);

    // R9 mixed extremes; R6 stray starts during feed and drain
    for (int j = 0; j < COLS; j++) V[j] = (1 << (DW - 1)) - 1;
    run_job("R6 R9 ghost", 1, COLS + 1);
    idle_cycles(4);

    // R6 stray start right after acceptance, then R8 hold over a long gap
    for (int p = 0; p < ROWS; p++)
      for (int j = 0; j < COLS; j++) A[p][j] = (p + 1) * (j % 2 == 0 ? 1 : -1);
    for (int j = 0; j < COLS; j++) V[j] = j + 1;
    run_job("R6 ghost early", 0, LAST_T - 1);
    idle_cycles(6);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule